// File: doc/BRIEF.md
# Equivalent Polynomial Table Expander

This block prepares the per-polynomial lookup table that a wide Toeplitz hash datapath needs before it can use a new feedback polynomial. The polynomial is given as the 128 coefficients that sit below an implied x^128 term. After a start strobe the block produces a table of 64 entries, one per clock. Entry i is x^(128+i) reduced modulo the full polynomial. Each entry appears on the output with its index, so a downstream engine can write it straight into its own table.

Every entry comes from the one before it by a left shift. When the top bit of the previous entry is set, the registered polynomial is XORed into the shifted value. The input polynomial is captured only when a start is accepted. A start that arrives while a table is still being produced is dropped. A completion pulse follows the last entry. This lets a polynomial that changes often and has many nonzero terms still feed a datapath that takes 64 bits per cycle, because the expansion is done once for each polynomial, before any data is hashed with it.

Top module: `eqp_expander`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` and `done` are 0 and `out_index` is 0.
- R2: One cycle after a start is accepted, `out_valid` is 1, `out_index` is 0 and `out_value` equals the polynomial present on `poly_in` when the start was accepted.
- R3: When bit 127 of entry i is 1, entry i+1 equals (entry i shifted left by one, bit 127 dropped, bit 0 filled with 0) XOR the captured polynomial.
- R4: When bit 127 of entry i is 0, entry i+1 equals entry i shifted left by one, with bit 127 dropped and bit 0 set to 0.
- R5: After an accepted start, `out_valid` is high for exactly 64 consecutive cycles, and `out_index` counts 0, 1, ..., 63 in them. Entry i equals x^(128+i) mod (x^128 + P).
- R6: `done` is high for exactly one cycle, the cycle right after index 63, and `out_valid` is 0 in that cycle.
- R7: A start that is asserted while `out_valid` is 1, including in the cycle of index 63, is ignored. The table in progress continues unchanged and is built from the original polynomial.
- R8: Changes on `poly_in` after a start has been accepted have no effect on the table being produced.
- R9: A start asserted in the cycle in which `done` is high is accepted. In the next cycle index 0 of the new table is on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe; accepted only when no table is in progress |
| poly_in | input | 128 | Polynomial coefficients x^0..x^127 (x^128 implied) |
| out_valid | output | 1 | High while a table entry is on the output |
| out_index | output | 6 | Index of the entry on the output |
| out_value | output | 128 | Entry value |
| done | output | 1 | One-cycle pulse after the last entry |

## Verification
A new start can coincide with the completion pulse. The bench provokes this by chaining tables back to back, raising start exactly in the `done` cycle, and then requires index 0 of the new polynomial in the next cycle. A start in the cycle of index 63 is a second coincidence, because the last entry and a would-be restart fall in the same cycle. The bench requires `done` to follow with no new table. It also drives a scrambled `poly_in` and stray starts during a table and compares every entry against a long-division reference computed in the bench.

// File: rtl/eqp_pkg.sv
package eqp_pkg;

    localparam int unsigned EQP_POLY_W  = 128;
    localparam int unsigned EQP_TABLE_N = 64;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXPAND = 2'd1,
        ST_FINISH = 2'd2
    } eqp_state_e;

endpackage

// File: rtl/eqp_step.sv
module eqp_step #(
    parameter int unsigned W = 128
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] base,
    output logic [W-1:0] nxt
);
    logic [W-1:0] shifted;
    logic [W-1:0] fold;

    assign shifted = {cur[W-2:0], 1'b0};

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_fold
            assign fold[b] = base[b] & cur[W-1];
        end
    endgenerate

    assign nxt = shifted ^ fold;
endmodule

// File: rtl/eqp_seq.sv
module eqp_seq
    import eqp_pkg::*;
#(
    parameter int unsigned N     = 64,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             load,
    output logic             advance,
    output logic             busy,
    output logic             finish,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    eqp_state_e state_q;

    assign load    = start && (state_q != ST_EXPAND);
    assign busy    = (state_q == ST_EXPAND);
    assign advance = busy && (idx != LAST);
    assign finish  = (state_q == ST_FINISH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx     <= '0;
        end else if (load) begin
            state_q <= ST_EXPAND;
            idx     <= '0;
        end else begin
            case (state_q)
                ST_EXPAND: begin
                    if (idx == LAST) state_q <= ST_FINISH;
                    else             idx     <= idx + 1'b1;
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assert_finish_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        finish |=> !finish);

    assert_no_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST) |=> (busy && idx == IDX_W'($past(idx) + 1'b1)));
endmodule

// File: rtl/eqp_expander.sv
module eqp_expander
    import eqp_pkg::*;
#(
    parameter int unsigned POLY_W  = EQP_POLY_W,
    parameter int unsigned TABLE_N = EQP_TABLE_N,
    localparam int unsigned IDX_W  = $clog2(TABLE_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [POLY_W-1:0] poly_in,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_index,
    output logic [POLY_W-1:0] out_value,
    output logic              done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TABLE_N - 1);

    logic              load;
    logic              advance;
    logic              busy;
    logic              finish;
    logic [IDX_W-1:0]  idx;
    logic [POLY_W-1:0] base_q;
    logic [POLY_W-1:0] entry_q;
    logic [POLY_W-1:0] entry_nxt;

    eqp_seq #(.N(TABLE_N), .IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .load    (load),
        .advance (advance),
        .busy    (busy),
        .finish  (finish),
        .idx     (idx)
    );

    eqp_step #(.W(POLY_W)) u_step (
        .cur  (entry_q),
        .base (base_q),
        .nxt  (entry_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            entry_q <= '0;
        end else if (load) begin
            base_q  <= poly_in;
            entry_q <= poly_in;
        end else if (advance) begin
            entry_q <= entry_nxt;
        end
    end

    assign out_valid = busy;
    assign out_index = idx;
    assign out_value = entry_q;
    assign done      = finish;

    assert_first_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !out_valid) |=> (out_valid && out_index == '0 && out_value == $past(poly_in)));

    assert_fold_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_index != LAST && out_value[POLY_W-1] && !start) |=>
        (out_value == ({$past(out_value[POLY_W-2:0]), 1'b0} ^ base_q)));

    assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_index != LAST && !out_value[POLY_W-1]) |=>
        (out_value == {$past(out_value[POLY_W-2:0]), 1'b0}));

    assert_last_then_done_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_index == LAST) |=> (done && !out_valid));

    assert_base_held_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> $stable(base_q));
endmodule

// File: tb/test_eqp_expander.sv
`timescale 1ns/1ps
module test_eqp_expander;
    localparam int W = 128;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] poly_in = '0;
    logic         out_valid;
    logic [5:0]   out_index;
    logic [W-1:0] out_value;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    eqp_expander i_eqp_expander (
        .clk(clk), .rst(rst), .start(start), .poly_in(poly_in),
        .out_valid(out_valid), .out_index(out_index),
        .out_value(out_value), .done(done)
    );

    // x^(128+i) mod (x^128 + p), by long division
    function automatic logic [W-1:0] ref_entry(input logic [W-1:0] p, input int i);
        logic [255:0] r;
        logic [255:0] m;
        r = 256'd1 << (W + i);
        m = {127'd0, 1'b1, p};
        for (int b = 255; b >= W; b--)
            if (r[b]) r = r ^ (m << (b - W));
        return r[W-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one table. If pre_started, start was already accepted in the previous cycle.
    task automatic run_table(input logic [W-1:0] p, input bit pre_started,
                             input int junk_at, input bit scramble,
                             input bit chain, input logic [W-1:0] next_p);
        if (!pre_started) begin
            poly_in = p;
            start   = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        for (int i = 0; i < N; i++) begin
            // R2 for i==0, R3/R4/R5 generally
            chk(out_valid && out_index == 6'(i), "R5 valid/index",
                {121'd0, out_valid, out_index}, {121'd0, 1'b1, 6'(i)});
            chk(out_value == ref_entry(p, i), (i == 0) ? "R2 entry0" : "R3/R4 entry",
                out_value, ref_entry(p, i));
            start = (i == junk_at);                        // R7 stray start
            if (scramble || i == junk_at) poly_in = ~p ^ W'(i * 32'h9E3779B9); // R8
            @(negedge clk);
            start = 1'b0;
        end
        chk(done && !out_valid, "R6 done after index 63",
            {126'd0, done, out_valid}, {126'd0, 1'b1, 1'b0});
        if (chain) begin
            poly_in = next_p;                              // R9 start in done cycle
            start   = 1'b1;
            @(negedge clk);
            start   = 1'b0;
        end else begin
            @(negedge clk);
            chk(!done && !out_valid, "R6 single pulse",
                {126'd0, done, out_valid}, 128'd0);
        end
    endtask

    initial begin
        logic [W-1:0] lcg;
        repeat (3) @(negedge clk);
        chk(!out_valid && !done && out_index == 0, "R1 in reset",
            {120'd0, out_valid, done, out_index}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !done && out_index == 0, "R1 after reset",
            {120'd0, out_valid, done, out_index}, 128'd0);

        run_table('0, 0, -1, 0, 0, '0);                  // all-zero polynomial
        run_table({W{1'b1}}, 0, -1, 0, 0, '0);           // dense
        run_table(W'(1), 0, -1, 0, 0, '0);
        run_table({1'b1, {(W-1){1'b0}}}, 0, -1, 0, 0, '0);
        run_table(128'h87, 0, -1, 1, 0, '0);             // R8 scrambled input
        run_table(128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE, 0, 10, 0, 0, '0);  // R7
        run_table(128'h5555_AAAA_5555_AAAA_1234_5678_9ABC_DEF0, 0, 63, 0, 0, '0);  // R7 at last
        // R9: back-to-back chain
        lcg = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
        run_table(lcg, 0, -1, 0, 1, lcg * 128'd6364136223846793005 + 128'd1442695040888963407);
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] cur;
            logic [W-1:0] nxt;
            cur = lcg * 128'd6364136223846793005 + 128'd1442695040888963407;
            nxt = cur * 128'd6364136223846793005 + 128'd1442695040888963407;
            run_table(cur, 1, -1, 0, (k != 5), nxt);
            lcg = cur;
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule